// File: doc/BRIEF.md
# Spectral Component Mixer with Noise Insertion

This block produces one test bit per clock for a single input of a combinational circuit under test. It keeps a small set of configured Walsh-line indices and chooses among those lines on every cycle, so that each chosen waveform is seen in a fixed proportion of cycles. After the choice, the chosen bit can be flipped by a weighted random noise bit. The output reproduces the spectral content of a stored test set instead of being plain pseudorandom data.

The Walsh bus, the selection bits and the noise bits all come from outside. Each selection bit and each noise bit is expected to be one with probability one half. The configuration holds the number of active components, one line index per component and a noise level. It is written only while the block is stopped. A two-state controller (`MIX_IDLE`, `MIX_RUN`) gates configuration writes and output generation. The transitions are GO (`MIX_IDLE` to `MIX_RUN` on `start`) and HALT (`MIX_RUN` to `MIX_IDLE` on `stop`). In every other case the state stays as it is.

With a count of two, one selection bit picks between the two components. With a count of three, a chain of selection bits gives proportions 0.5, 0.25 and 0.25. The noise level k gives the noise bit a weight of 2^-k.

Top module: `spectral_mixer`

## Requirements
- R1: After reset the state is `MIX_IDLE`, `active` is 0 and `test_bit` is 0. The configuration is all zeros: a count of 0, every index 0 and a noise level of 0. Starting without any write therefore gives `test_bit` equal to `walsh[0]`.
- R2: `cfg_we` loads `cfg_count`, `cfg_index` and `cfg_noise_lvl` at a clock edge only in `MIX_IDLE`. In `MIX_RUN` a write has no effect.
- R3: GO moves `MIX_IDLE` to `MIX_RUN` when `start` is 1, and HALT moves `MIX_RUN` to `MIX_IDLE` when `stop` is 1. `active` is 1 exactly in `MIX_RUN`. After any edge taken in `MIX_IDLE`, `test_bit` is 0.
- R4: With a count of 0 or 1, the edge taken in `MIX_RUN` registers `walsh[index0] ^ noise` into `test_bit`. Index k occupies `cfg_index[k*IDX_W +: IDX_W]`.
- R5: With a count of 2, `sel_rnd[0]=1` chooses component 1 and `sel_rnd[0]=0` chooses component 0. `sel_rnd[1]` is ignored.
- R6: With a count of 3, `sel_rnd[0]=1` chooses component 2. Otherwise `sel_rnd[1]=1` chooses component 1, and if both bits are 0 the block chooses component 0. With fair selection bits the proportions are 0.25, 0.25 and 0.5.
- R7: The noise bit is the AND of `noise_rnd[0]` through `noise_rnd[L-1]` for a noise level L, and it is XORed into the chosen bit. A level of 0 disables noise. Level 2 with fair bits flips a quarter of the bits.
- R8: A noise level above `NOISE_BITS` acts as `NOISE_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | GO request |
| stop | input | 1 | HALT request |
| cfg_we | input | 1 | Configuration write strobe, honoured only when idle |
| cfg_count | input | CNT_W | Number of active components (0 acts as 1) |
| cfg_index | input | MAX_COMP*IDX_W | Packed Walsh-line index per component |
| cfg_noise_lvl | input | LVL_W | Noise level L, noise weight 2^-L |
| walsh | input | WALSH_W | Walsh function lines |
| sel_rnd | input | SEL_W | Weight-0.5 selection bits |
| noise_rnd | input | NOISE_BITS | Weight-0.5 noise bits |
| active | output | 1 | High in `MIX_RUN` |
| test_bit | output | 1 | Registered test bit |

## Verification
A corrupted configuration register or selection chain shows up at the port on the very next edge. It appears as a `test_bit` that differs from the Walsh line the selection bits call for, and the directed vector table exposes this in one cycle per vector. A wrong weighting in the chain or the noise AND cannot be seen from one sample. It appears only as a shifted ratio of ones over a few thousand cycles, which the statistical runs measure. A controller stuck in the wrong state shows up within one cycle: either `active` is wrong, or the output stays zero while running, or the output follows the data while idle.

// File: rtl/spectral_mix_pkg.sv
package spectral_mix_pkg;
    typedef enum logic {
        MIX_IDLE = 1'b0,
        MIX_RUN  = 1'b1
    } mix_state_e;
endpackage

// File: rtl/spectral_mix_ctrl.sv
module spectral_mix_ctrl
    import spectral_mix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic cfg_we,
    output logic running,
    output logic cfg_load
);
    mix_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MIX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MIX_IDLE: if (start) state_d = MIX_RUN;   // GO
            MIX_RUN:  if (stop)  state_d = MIX_IDLE;  // HALT
            default:  state_d = MIX_IDLE;
        endcase
    end

    always_comb begin
        running  = 1'b0;
        cfg_load = 1'b0;
        unique case (state_q)
            MIX_IDLE: cfg_load = cfg_we;
            MIX_RUN:  running  = 1'b1;
            default:  running  = 1'b0;
        endcase
    end
endmodule

// File: rtl/spectral_mix_cfg.sv
module spectral_mix_cfg #(
    parameter int MAX_COMP = 3,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 2,
    parameter int LVL_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [CNT_W-1:0]          count_in,
    input  logic [MAX_COMP*IDX_W-1:0] index_in,
    input  logic [LVL_W-1:0]          lvl_in,
    output logic [CNT_W-1:0]          count_q,
    output logic [MAX_COMP*IDX_W-1:0] index_q,
    output logic [LVL_W-1:0]          lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            index_q <= '0;
            lvl_q   <= '0;
        end else if (load) begin
            count_q <= count_in;
            index_q <= index_in;
            lvl_q   <= lvl_in;
        end
    end
endmodule

// File: rtl/spectral_mix_select.sv
module spectral_mix_select #(
    parameter int WALSH_W  = 8,
    parameter int MAX_COMP = 3,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 2,
    parameter int SEL_W    = 2
) (
    input  logic [WALSH_W-1:0]        walsh,
    input  logic [MAX_COMP*IDX_W-1:0] index_q,
    input  logic [CNT_W-1:0]          count_q,
    input  logic [SEL_W-1:0]          sel_rnd,
    output logic                      comp_bit
);
    int          eff_cnt;
    int          pick;
    logic        found;
    logic [IDX_W-1:0] line;

    always_comb begin
        eff_cnt = int'(count_q);
        if (eff_cnt < 1)        eff_cnt = 1;
        if (eff_cnt > MAX_COMP) eff_cnt = MAX_COMP;
        pick  = 0;
        found = 1'b0;
        // Bit k of the chain claims component (count-1-k) with weight one half.
        for (int k = 0; k < MAX_COMP - 1; k++) begin
            if (k < eff_cnt - 1 && !found && sel_rnd[k]) begin
                pick  = eff_cnt - 1 - k;
                found = 1'b1;
            end
        end
        line     = index_q[pick*IDX_W +: IDX_W];
        comp_bit = (int'(line) < WALSH_W) ? walsh[line] : 1'b0;
    end
endmodule

// File: rtl/spectral_mix_noise.sv
module spectral_mix_noise #(
    parameter int NOISE_BITS = 4,
    parameter int LVL_W      = 3
) (
    input  logic [NOISE_BITS-1:0] noise_rnd,
    input  logic [LVL_W-1:0]      lvl_q,
    output logic                  noise_bit
);
    int eff_lvl;

    always_comb begin
        eff_lvl = int'(lvl_q);
        if (eff_lvl > NOISE_BITS) eff_lvl = NOISE_BITS;
        noise_bit = (eff_lvl != 0);
        for (int k = 0; k < NOISE_BITS; k++) begin
            if (k < eff_lvl) noise_bit = noise_bit & noise_rnd[k];
        end
    end
endmodule

// File: rtl/spectral_mixer.sv
module spectral_mixer #(
    parameter int WALSH_W    = 8,
    parameter int MAX_COMP   = 3,
    parameter int NOISE_BITS = 4,
    localparam int IDX_W     = (WALSH_W > 1) ? $clog2(WALSH_W) : 1,
    localparam int CNT_W     = $clog2(MAX_COMP + 1),
    localparam int LVL_W     = $clog2(NOISE_BITS + 1),
    localparam int SEL_W     = (MAX_COMP > 1) ? MAX_COMP - 1 : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      stop,
    input  logic                      cfg_we,
    input  logic [CNT_W-1:0]          cfg_count,
    input  logic [MAX_COMP*IDX_W-1:0] cfg_index,
    input  logic [LVL_W-1:0]          cfg_noise_lvl,
    input  logic [WALSH_W-1:0]        walsh,
    input  logic [SEL_W-1:0]          sel_rnd,
    input  logic [NOISE_BITS-1:0]     noise_rnd,
    output logic                      active,
    output logic                      test_bit
);
    logic                      cfg_load;
    logic [CNT_W-1:0]          count_q;
    logic [MAX_COMP*IDX_W-1:0] index_q;
    logic [LVL_W-1:0]          lvl_q;
    logic                      comp_bit;
    logic                      noise_bit;
    logic                      bit_q;

    spectral_mix_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_we(cfg_we), .running(active), .cfg_load(cfg_load)
    );

    spectral_mix_cfg #(
        .MAX_COMP(MAX_COMP), .IDX_W(IDX_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .count_in(cfg_count), .index_in(cfg_index), .lvl_in(cfg_noise_lvl),
        .count_q(count_q), .index_q(index_q), .lvl_q(lvl_q)
    );

    spectral_mix_select #(
        .WALSH_W(WALSH_W), .MAX_COMP(MAX_COMP), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_sel (
        .walsh(walsh), .index_q(index_q), .count_q(count_q),
        .sel_rnd(sel_rnd), .comp_bit(comp_bit)
    );

    spectral_mix_noise #(
        .NOISE_BITS(NOISE_BITS), .LVL_W(LVL_W)
    ) u_noise (
        .noise_rnd(noise_rnd), .lvl_q(lvl_q), .noise_bit(noise_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (active) bit_q <= comp_bit ^ noise_bit;
        else             bit_q <= 1'b0;
    end

    assign test_bit = bit_q;
endmodule

// File: rtl/spectral_mixer_chk.sv
module spectral_mixer_chk #(
    parameter int WALSH_W  = 8,
    parameter int MAX_COMP = 3,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 2,
    parameter int LVL_W    = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      stop,
    input logic                      active,
    input logic                      test_bit,
    input logic [WALSH_W-1:0]        walsh,
    input logic [CNT_W-1:0]          count_q,
    input logic [MAX_COMP*IDX_W-1:0] index_q,
    input logic [LVL_W-1:0]          lvl_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !test_bit); // R3
    AST_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start) |=> active); // R3
    AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && stop) |=> !active); // R3
    AST_STAY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !stop) |=> active); // R3
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(count_q) && $stable(index_q) && $stable(lvl_q))); // R2
    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && count_q <= 1 && lvl_q == 0)
        |=> test_bit == $past(walsh[index_q[IDX_W-1:0]])); // R4
endmodule

bind spectral_mixer spectral_mixer_chk #(
    .WALSH_W(WALSH_W), .MAX_COMP(MAX_COMP), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .active(active), .test_bit(test_bit), .walsh(walsh),
    .count_q(count_q), .index_q(index_q), .lvl_q(lvl_q)
);

// File: tb/spectral_mixer_bench.sv
`timescale 1ns/1ps
module spectral_mixer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stop = 1'b0, cfg_we = 1'b0;
    logic [1:0] cfg_count = '0;
    logic [8:0] cfg_index = '0;
    logic [2:0] cfg_noise_lvl = '0;
    logic [7:0] walsh = '0;
    logic [1:0] sel_rnd = '0;
    logic [3:0] noise_rnd = '0;
    logic       active, test_bit;
    int         n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    spectral_mixer u_spectral_mixer (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_we(cfg_we),
        .cfg_count(cfg_count), .cfg_index(cfg_index), .cfg_noise_lvl(cfg_noise_lvl),
        .walsh(walsh), .sel_rnd(sel_rnd), .noise_rnd(noise_rnd),
        .active(active), .test_bit(test_bit)
    );

    typedef struct packed {
        logic [1:0] cnt;
        logic [2:0] i0, i1, i2;
        logic [2:0] lvl;
        logic [7:0] wv;
        logic [1:0] sel;
        logic [3:0] nz;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TABLE [NV] = '{
        '{2'd1, 3'd5, 3'd0, 3'd0, 3'd0, 8'h20, 2'b00, 4'h0, 1'b1, 4'd4}, // R4
        '{2'd1, 3'd5, 3'd0, 3'd0, 3'd0, 8'h00, 2'b00, 4'hF, 1'b0, 4'd7}, // R7 level 0
        '{2'd1, 3'd5, 3'd0, 3'd0, 3'd1, 8'h20, 2'b00, 4'h1, 1'b0, 4'd7}, // R7
        '{2'd1, 3'd5, 3'd0, 3'd0, 3'd2, 8'h20, 2'b00, 4'h1, 1'b1, 4'd7}, // R7
        '{2'd1, 3'd5, 3'd0, 3'd0, 3'd2, 8'h00, 2'b00, 4'h3, 1'b1, 4'd7}, // R7
        '{2'd2, 3'd1, 3'd6, 3'd0, 3'd0, 8'h40, 2'b01, 4'h0, 1'b1, 4'd5}, // R5
        '{2'd2, 3'd1, 3'd6, 3'd0, 3'd0, 8'h40, 2'b00, 4'h0, 1'b0, 4'd5}, // R5
        '{2'd2, 3'd1, 3'd6, 3'd0, 3'd0, 8'h02, 2'b10, 4'h0, 1'b1, 4'd5}, // R5
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd0, 8'h80, 2'b10, 4'h0, 1'b0, 4'd6}, // R6
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd0, 8'h80, 2'b11, 4'h0, 1'b1, 4'd6}, // R6
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd0, 8'h08, 2'b10, 4'h0, 1'b1, 4'd6}, // R6
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd0, 8'h01, 2'b00, 4'h0, 1'b1, 4'd6}, // R6
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd0, 8'h01, 2'b01, 4'h0, 1'b0, 4'd6}, // R6
        '{2'd0, 3'd2, 3'd0, 3'd0, 3'd0, 8'h04, 2'b11, 4'h0, 1'b1, 4'd4}, // R4 count 0
        '{2'd1, 3'd0, 3'd0, 3'd0, 3'd7, 8'h00, 2'b00, 4'hF, 1'b1, 4'd8}, // R8
        '{2'd1, 3'd0, 3'd0, 3'd0, 3'd7, 8'h00, 2'b00, 4'h7, 1'b0, 4'd8}, // R8
        '{2'd3, 3'd0, 3'd3, 3'd7, 3'd1, 8'h80, 2'b01, 4'h1, 1'b0, 4'd7}  // R7 with R6
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] c, input logic [8:0] idx, input logic [2:0] l);
        @(negedge clk); stop = 1'b1; start = 1'b0;
        @(negedge clk); stop = 1'b0; cfg_we = 1'b1;
        cfg_count = c; cfg_index = idx; cfg_noise_lvl = l;
        @(negedge clk); cfg_we = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic ratio(input string tag, input int exp_ones, input int tol);
        int ones = 0;
        for (int i = 0; i < 4000; i++) begin
            sel_rnd = 2'($urandom); noise_rnd = 4'($urandom);
            @(negedge clk);
            ones += int'(test_bit);
        end
        n_chk++;
        if (ones < exp_ones - tol || ones > exp_ones + tol) begin
            n_bad++;
            $display("FAIL %s: got %0d ones expected %0d", tag, ones, exp_ones);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        walsh = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 active after reset", active, 1'b0);
        check("R1 test_bit after reset", test_bit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 idle output quiet", test_bit, 1'b0);
        // R1: reset configuration reads walsh[0], no noise
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R3 GO raises active", active, 1'b1);
        walsh = 8'h01; noise_rnd = 4'hF; @(negedge clk);
        check("R1 default passes line 0", test_bit, 1'b1);
        walsh = 8'hFE; @(negedge clk);
        check("R1 default passes line 0 low", test_bit, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            configure(TABLE[v].cnt, {TABLE[v].i2, TABLE[v].i1, TABLE[v].i0}, TABLE[v].lvl);
            walsh = TABLE[v].wv; sel_rnd = TABLE[v].sel; noise_rnd = TABLE[v].nz;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TABLE[v].req, v), test_bit, TABLE[v].exp);
        end

        // R2: write while running is ignored
        configure(2'd1, 9'd5, 3'd0);
        cfg_we = 1'b1; cfg_index = 9'd2; cfg_count = 2'd1;
        @(negedge clk); cfg_we = 1'b0;
        walsh = 8'h20; noise_rnd = 4'h0;
        @(negedge clk);
        check("R2 write in run ignored", test_bit, 1'b1);
        walsh = 8'h04; @(negedge clk);
        check("R2 write in run ignored low", test_bit, 1'b0);

        // R3: HALT, then output idle zero
        stop = 1'b1; walsh = 8'hFF; @(negedge clk); stop = 1'b0;
        check("R3 HALT drops active", active, 1'b0);
        @(negedge clk);
        check("R3 idle output zero", test_bit, 1'b0);

        // Statistical proportions
        configure(2'd2, {3'd0, 3'd4, 3'd1}, 3'd0);
        walsh = 8'h10; ratio("R5 two-way half", 2000, 180);
        configure(2'd3, {3'd7, 3'd3, 3'd0}, 3'd0);
        walsh = 8'h80; ratio("R6 three-way comp2 half", 2000, 180);
        walsh = 8'h01; ratio("R6 three-way comp0 quarter", 1000, 150);
        walsh = 8'h08; ratio("R6 three-way comp1 quarter", 1000, 150);
        configure(2'd1, 9'd0, 3'd2);
        walsh = 8'h00; ratio("R7 noise level 2 quarter", 1000, 150);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule